// File: doc/BRIEF.md
# Countdown Watchdog Timer with Register Access

This block is a watchdog peripheral reached through a plain 32-bit register port: a write strobe, a byte address, write data, and combinational read data. It holds two registers. One is a down-counter and the other is a configuration word. Software arms the watchdog by writing a nonzero tick count to the counter. It keeps the system alive by writing that count again before the count runs out. Writing zero disarms the watchdog. While the count is above one, the counter loses one on every enabled tick.

The tick comes from one of two sources, chosen by a configuration bit. One source is every system clock cycle. The other is a crystal-derived tick-enable input. When the count arrives at one, the block drives a fixed-length system reset pulse, unless the configuration disable flag is set. After the pulse the counter rests at one. Software reads the live count to work out the time remaining, which is (count − 1) / tick rate. Writing the value one therefore triggers a reset from software.

Top module: `wdt_countdown`

## Requirements
- R1: After power-on reset, the counter reads 0, the configuration register reads 0, and `sys_rst_o` is low.
- R2: A write to byte offset 0 loads the counter on that clock edge, overriding any count in progress. A read of offset 0 returns the live count.
- R3: With configuration bit 0 clear, the counter decrements by exactly one on every clock while its value is above 1.
- R4: With configuration bit 0 set, the counter decrements only on clocks where `xtal_tick` is high.
- R5: A count of 0 is inactive. The count stays 0 and no reset is produced until the counter is written.
- R6: When the count is 1 and the disable flag is clear, `sys_rst_o` goes high on the next clock and stays high for PULSE_LEN cycles, exactly once. The counter stays at 1 until it is written. A new pulse can start no sooner than one low cycle after the previous one.
- R7: Writing 1 to the counter while no pulse is active raises `sys_rst_o` one clock after the write edge.
- R8: While configuration bit 31 is set, no reset pulse starts, but counting still proceeds down to 1. Clearing the bit while the count is 1 starts the pulse on the following clock.
- R9: A read of byte offset 4 returns bit 31 (disable) and bit 0 (crystal source) as written, with all other bits 0. Reads of other offsets return 0, and writes to them change nothing.
- R10: The full 32-bit value 0xFFFFFFFF loads and counts down like any other value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous power-on reset |
| xtal_tick | input | 1 | Crystal-derived tick enable, one clock wide per tick |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| sys_rst_o | output | 1 | Registered system reset pulse, active high |

## Verification
A wrong count shows up on the very next read of offset 0, because the bench compares the read data every cycle against a cycle-level model. A lost or extra decrement is therefore caught in the cycle it happens. A wrong fired or busy flag, or a wrong disable decision, shows on `sys_rst_o` within one clock of the count reaching 1 or of a write of 1. A wrong pulse length shows within PULSE_LEN + 1 cycles. A configuration register that latched the wrong bits changes the decrement rate, which becomes visible on the following counter reads.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
   // Byte offsets decoded by the register port
   localparam int unsigned OFS_COUNT   = 0;
   localparam int unsigned OFS_CONFIG  = 4;
   // Configuration bit positions
   localparam int unsigned CFG_SRC_BIT = 0;
   localparam int unsigned CFG_OFF_BIT = 31;
endpackage

// File: rtl/wdt_regfile.sv
module wdt_regfile #(
   parameter int unsigned ADDR_W = 4,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned CNT_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic [CNT_W-1:0]  cnt_i,
   output logic              cnt_wr_o,
   output logic              src_xtal_o,
   output logic              cfg_off_o,
   output logic [DATA_W-1:0] bus_rdata
);
   import wdt_pkg::*;

   localparam logic [ADDR_W-1:0] A_CNT = ADDR_W'(OFS_COUNT);
   localparam logic [ADDR_W-1:0] A_CFG = ADDR_W'(OFS_CONFIG);

   logic hit_cnt, hit_cfg;
   logic src_q, off_q;

   assign hit_cnt  = (bus_addr == A_CNT);
   assign hit_cfg  = (bus_addr == A_CFG);
   assign cnt_wr_o = bus_we && hit_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_q <= 1'b0;
         off_q <= 1'b0;
      end else if (bus_we && hit_cfg) begin
         src_q <= bus_wdata[CFG_SRC_BIT];
         off_q <= bus_wdata[CFG_OFF_BIT];
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (hit_cnt) begin
         bus_rdata = DATA_W'(cnt_i);
      end else if (hit_cfg) begin
         bus_rdata[CFG_SRC_BIT] = src_q;
         bus_rdata[CFG_OFF_BIT] = off_q;
      end
   end

   assign src_xtal_o = src_q;
   assign cfg_off_o  = off_q;
endmodule

// File: rtl/wdt_tick_sel.sv
module wdt_tick_sel #(
   parameter bit HAS_XTAL = 1'b1
) (
   input  logic xtal_tick,
   input  logic use_xtal,
   output logic tick_o
);
   generate
      if (HAS_XTAL) begin : g_sel
         assign tick_o = use_xtal ? xtal_tick : 1'b1;
      end else begin : g_sysclk
         logic unused_in;
         assign unused_in = ^{xtal_tick, use_xtal};
         assign tick_o    = 1'b1;
      end
   endgenerate
endmodule

// File: rtl/wdt_down_counter.sv
module wdt_down_counter #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   input  logic             tick_i,
   input  logic             allow_i,
   input  logic             busy_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             fire_o
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;
   logic             fired_q;

   assign fire_o = (cnt_q == ONE) && allow_i && !fired_q && !busy_i;
   assign cnt_o  = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         fired_q <= 1'b0;
      end else begin
         if (load_i) begin
            cnt_q <= load_val_i;
         end else if (tick_i && (cnt_q > ONE)) begin
            cnt_q <= cnt_q - ONE;
         end
         if (load_i) begin
            fired_q <= 1'b0;
         end else if (fire_o) begin
            fired_q <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/wdt_rst_pulse.sv
module wdt_rst_pulse #(
   parameter int unsigned PULSE_LEN = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fire_i,
   output logic busy_o,
   output logic rst_o
);
   logic rst_q;

   generate
      if (PULSE_LEN == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rst_q <= 1'b0;
            else        rst_q <= fire_i;
         end
         assign busy_o = rst_q;
      end else begin : g_multi
         localparam int unsigned PW = $clog2(PULSE_LEN + 1);
         logic [PW-1:0] left_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               left_q <= '0;
               rst_q  <= 1'b0;
            end else begin
               if (fire_i)               left_q <= PW'(PULSE_LEN);
               else if (left_q != '0)    left_q <= left_q - PW'(1);
               rst_q <= fire_i || (left_q > PW'(1));
            end
         end
         assign busy_o = (left_q != '0);
      end
   endgenerate

   assign rst_o = rst_q;
endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown #(
   parameter int unsigned ADDR_W    = 4,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned CNT_W     = 32,
   parameter int unsigned PULSE_LEN = 4,
   parameter bit          HAS_XTAL  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              xtal_tick,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              sys_rst_o
);
   generate
      if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_cnt
         $error("CNT_W must lie in 2..DATA_W");
      end
      if (DATA_W != 32) begin : g_bad_data
         $error("DATA_W must be 32 to hold the configuration bits");
      end
      if (ADDR_W < 3) begin : g_bad_addr
         $error("ADDR_W must reach byte offset 4");
      end
      if (PULSE_LEN < 1) begin : g_bad_pulse
         $error("PULSE_LEN must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;
   logic             cnt_wr, src_xtal, cfg_off, tick, fire, busy;

   wdt_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .cnt_i(cnt_q), .cnt_wr_o(cnt_wr),
      .src_xtal_o(src_xtal), .cfg_off_o(cfg_off), .bus_rdata(bus_rdata)
   );

   wdt_tick_sel #(.HAS_XTAL(HAS_XTAL)) u_tick (
      .xtal_tick(xtal_tick), .use_xtal(src_xtal), .tick_o(tick)
   );

   wdt_down_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .load_i(cnt_wr),
      .load_val_i(bus_wdata[CNT_W-1:0]), .tick_i(tick),
      .allow_i(!cfg_off), .busy_i(busy), .cnt_o(cnt_q), .fire_o(fire)
   );

   wdt_rst_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
      .clk(clk), .rst_n(rst_n), .fire_i(fire), .busy_o(busy), .rst_o(sys_rst_o)
   );
endmodule

// File: rtl/wdt_countdown_chk.sv
module wdt_countdown_chk #(
   parameter int unsigned ADDR_W    = 4,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned CNT_W     = 32,
   parameter int unsigned PULSE_LEN = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [CNT_W-1:0]  cnt,
   input logic              cfg_off,
   input logic              sys_rst_o
);
   logic cwr;
   int unsigned hi_run;

   assign cwr = bus_we && (bus_addr == ADDR_W'(wdt_pkg::OFS_COUNT));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         hi_run <= 0;
      else if (sys_rst_o) hi_run <= hi_run + 1;
      else                hi_run <= 0;
   end

   AST_PULSE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      hi_run <= PULSE_LEN); // R6
   AST_FLOOR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!cwr && cnt == CNT_W'(1)) |=> cnt == CNT_W'(1)); // R6
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!cwr && cnt == '0) |=> cnt == '0); // R5
   AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!cwr && cnt > CNT_W'(1)) |=> (cnt == $past(cnt) || cnt == $past(cnt) - CNT_W'(1))); // R3
   AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_off && !sys_rst_o) |=> !sys_rst_o); // R8
   AST_SW_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      (cwr && bus_wdata[CNT_W-1:0] == CNT_W'(1) && !cfg_off && !sys_rst_o) |-> ##2 sys_rst_o); // R7
endmodule

bind wdt_countdown wdt_countdown_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .PULSE_LEN(PULSE_LEN)
) chk_i (
   .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
   .bus_wdata(bus_wdata), .cnt(cnt_q), .cfg_off(cfg_off), .sys_rst_o(sys_rst_o)
);

// File: tb/wdt_countdown_tb.sv
module wdt_countdown_tb_top;
   localparam int unsigned PL = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        xtal_tick = 1'b0;
   logic        bus_we = 1'b0;
   logic [3:0]  bus_addr = 4'd0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        sys_rst_o;

   int checks = 0;
   int fails  = 0;

   // bench reference state
   logic [31:0] m_cnt = '0;
   logic        m_x = 1'b0, m_d = 1'b0, m_fired = 1'b0, m_rst = 1'b0;
   int          m_left = 0;

   always #5 clk = ~clk;

   wdt_countdown #(.PULSE_LEN(PL)) dut_i (
      .clk(clk), .rst_n(rst_n), .xtal_tick(xtal_tick), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .sys_rst_o(sys_rst_o)
   );

   function automatic logic [31:0] exp_read(input logic [3:0] a);
      if (a == 4'd0) return m_cnt;
      if (a == 4'd4) return {m_d, 30'd0, m_x};
      return 32'd0;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // advance the reference by one clock edge with the driven inputs
   task automatic model_edge(input logic we, input logic [3:0] a, input logic [31:0] d, input logic xt);
      logic start, tick;
      start = (m_cnt == 32'd1) && !m_d && !m_fired && (m_left == 0);
      tick  = m_x ? xt : 1'b1;
      m_rst = start || (m_left > 1);
      if (start)           m_left = PL;
      else if (m_left > 0) m_left = m_left - 1;
      if (we && a == 4'd0)         m_fired = 1'b0;
      else if (start)              m_fired = 1'b1;
      if (we && a == 4'd0)         m_cnt = d;
      else if (tick && m_cnt > 1)  m_cnt = m_cnt - 1;
      if (we && a == 4'd4) begin
         m_x = d[0];
         m_d = d[31];
      end
   endtask

   task automatic step(input logic we, input logic [3:0] a, input logic [31:0] d,
                       input logic xt, input string tag);
      bus_we = we; bus_addr = a; bus_wdata = d; xtal_tick = xt;
      @(posedge clk);
      model_edge(we, a, d, xt);
      @(negedge clk);
      bus_we = 1'b0;
      xtal_tick = 1'b0;
      #1;
      chk({tag, " rst"}, {31'd0, sys_rst_o}, {31'd0, m_rst});
      chk({tag, " read"}, bus_rdata, exp_read(a));
   endtask

   task automatic idle(input int n, input logic [3:0] a, input string tag);
      for (int i = 0; i < n; i++) step(1'b0, a, 32'd0, 1'b0, tag);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin : stim
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      bus_addr = 4'd0; #1;
      chk("R1 count", bus_rdata, 32'd0);
      chk("R1 rst", {31'd0, sys_rst_o}, 32'd0);
      bus_addr = 4'd4; #1;
      chk("R1 config", bus_rdata, 32'd0);
      @(negedge clk); rst_n = 1'b1;

      step(1'b1, 4'd0, 32'd5, 1'b0, "R2");
      chk("R2 literal load", bus_rdata, 32'd5);
      idle(2, 4'd0, "R3");
      chk("R3 literal two ticks", bus_rdata, 32'd3);
      idle(3, 4'd0, "R6");
      chk("R6 pulse high", {31'd0, sys_rst_o}, 32'd1);
      idle(8, 4'd0, "R6");
      chk("R6 counter rests", bus_rdata, 32'd1);
      chk("R6 single pulse", {31'd0, sys_rst_o}, 32'd0);

      step(1'b1, 4'd0, 32'd0, 1'b0, "R5");
      idle(6, 4'd0, "R5");
      chk("R5 inactive", bus_rdata, 32'd0);

      step(1'b1, 4'd4, 32'd1, 1'b0, "R9");
      chk("R9 src bit", bus_rdata, 32'd1);
      step(1'b1, 4'd0, 32'd10, 1'b0, "R4");
      for (int i = 0; i < 10; i++) step(1'b0, 4'd0, 32'd0, i[0], "R4");
      chk("R4 half rate", bus_rdata, 32'd5);

      step(1'b1, 4'd4, 32'h8000_0000, 1'b0, "R8");
      step(1'b1, 4'd0, 32'd3, 1'b0, "R8");
      idle(6, 4'd0, "R8");
      chk("R8 reached one", bus_rdata, 32'd1);
      chk("R8 no reset", {31'd0, sys_rst_o}, 32'd0);
      step(1'b1, 4'd4, 32'h0000_0000, 1'b0, "R8");
      step(1'b0, 4'd0, 32'd0, 1'b0, "R8");
      chk("R8 released", {31'd0, sys_rst_o}, 32'd1);
      idle(6, 4'd0, "R8");

      step(1'b1, 4'd0, 32'd1, 1'b0, "R7");
      step(1'b0, 4'd0, 32'd0, 1'b0, "R7");
      chk("R7 immediate", {31'd0, sys_rst_o}, 32'd1);
      idle(6, 4'd0, "R7");

      step(1'b1, 4'd0, 32'hFFFF_FFFF, 1'b0, "R10");
      step(1'b0, 4'd0, 32'd0, 1'b0, "R10");
      chk("R10 max decrements", bus_rdata, 32'hFFFF_FFFE);
      step(1'b1, 4'd0, 32'd9, 1'b0, "R2");
      chk("R2 override", bus_rdata, 32'd9);

      step(1'b1, 4'd8, 32'h8000_0001, 1'b0, "R9");
      chk("R9 unmapped", bus_rdata, 32'd0);
      step(1'b0, 4'd4, 32'd0, 1'b0, "R9");
      chk("R9 config untouched", bus_rdata, 32'd0);

      for (int i = 0; i < 4000; i++) begin
         int unsigned r;
         logic        xt;
         r  = $urandom_range(0, 99);
         xt = ($urandom_range(0, 9) < 3);
         if (r < 8)
            step(1'b1, 4'd0, 32'($urandom_range(0, 14)), xt, "R2 rnd");
         else if (r < 10)
            step(1'b1, 4'd4, {1'($urandom_range(0, 1)), 30'd0, 1'($urandom_range(0, 1))}, xt, "R9 rnd");
         else if (r < 12)
            step(1'b1, 4'd8, $urandom, xt, "R9 rnd");
         else
            step(1'b0, (r < 80) ? 4'd0 : 4'd4, 32'd0, xt, "R6 rnd");
      end

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule